// File: doc/BRIEF.md
# Gigabit Fiber Link Auto-Negotiation Controller

This block runs the configuration exchange that brings up a 1000BASE-X fiber link. Once enabled it first sends all-zero configuration words for one link-timer period. It then sends its own 16-bit ability word and waits until the partner's word has been received unchanged several times. Next it raises the acknowledge bit in its own word and waits for the partner to acknowledge in the same way. After one more timer period with the acknowledge still set, and one quiet period with no configuration sets sent, it reports the link as negotiated.

Received configuration words arrive on a valid/ready stream. The block never applies back-pressure: `rx_cfg_ready` is always high, and a word is consumed on every clock edge where `rx_cfg_valid` is high. Cycles without valid are gaps and are ignored. The transmit word, the activity flag and all status outputs are plain levels driven from the state register.

The link timer normally counts 1,250,000 cycles (10 ms at 125 MHz). A debug pin selects a short count instead, which keeps simulations brief. The management controls and the synchronization status can send the machine back to its starting state at any time.

Top module: `an_cl37_ctrl`

## Requirements
- R1: While `an_enable` is low, or after reset, the outputs are as follows: `tx_cfg_active`=0, `an_complete`=0, `page_rx`=0 and `lp_ability`=0.
- R2: After a restart with `an_enable` high, the block sends `tx_cfg_word`=0x0000 with `tx_cfg_active`=1 for exactly one link-timer period.
- R3: The link-timer period is `SHORT_TICKS` cycles when `timer_short`=1 and `LONG_TICKS` cycles when `timer_short`=0.
- R4: While detecting ability, a partner word is accepted once `MATCH_COUNT` (3) consecutive valid words are identical when bit 14 is ignored. Invalid cycles do not break the run. A differing word starts a new run. Words that are zero apart from bit 14 are never accepted.
- R5: While detecting ability, `tx_cfg_word` equals `adv_ability` with bit 14 cleared.
- R6: After ability is accepted, `tx_cfg_word` equals `adv_ability` with bit 14 set. The block advances only after 3 consecutive valid words that have bit 14 set and match the accepted ability in every other bit.
- R7: `page_rx` is high exactly during the complete-acknowledge state, which lasts one link-timer period. During that state `tx_cfg_word` still carries bit 14.
- R8: After complete-acknowledge, `tx_cfg_active` is low for one link-timer period. Then `an_complete` rises and stays high.
- R9: `lp_ability` shows the most recently accepted partner word, including its bit 14. With 0x0020 advertised and a partner sending 0x4020, it reads 0x4020 at completion and holds while complete.
- R10: A high `main_reset` or `an_restart` returns the machine to its start. The following cycle shows `an_complete`=0, `tx_cfg_active`=0 and `lp_ability`=0.
- R11: If `sync_ok` is low for `SYNC_LOSS_CYCLES` consecutive cycles, negotiation restarts. A shorter loss has no effect.
- R12: `rx_cfg_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| an_enable | input | 1 | Enables negotiation |
| an_restart | input | 1 | Restarts negotiation while high |
| main_reset | input | 1 | Forces the machine to its start while high |
| timer_short | input | 1 | Selects the short debug link-timer period |
| sync_ok | input | 1 | Receive code-group alignment is held |
| adv_ability | input | 16 | Local ability word to advertise |
| rx_cfg_valid | input | 1 | Received configuration word is valid |
| rx_cfg_ready | output | 1 | Always high; no back-pressure |
| rx_cfg_word | input | 16 | Received configuration word |
| tx_cfg_word | output | 16 | Configuration word to transmit |
| tx_cfg_active | output | 1 | Configuration sets are being sent |
| lp_ability | output | 16 | Accepted partner ability |
| page_rx | output | 1 | High during complete-acknowledge |
| an_complete | output | 1 | Negotiation finished |

## Verification
The bench sweeps full negotiations over many pairs of advertised and partner words, in both timer modes. For each it measures the restart, complete-acknowledge and quiet periods cycle by cycle, so an off-by-one timer or a swapped timer select shows up as a wrong count. It then targets the consistency detector with several patterns: gaps inside a run, a differing word that restarts a run, runs where only bit 14 changes, and zero words. A detector that failed to reset its run, or that treated bit 14 as significant, would accept too early or too late. Finally it checks that an acknowledge stage without bit 14 stalls, that both management controls clear the outputs, and that synchronization loss one cycle short of the limit leaves the link up while a loss of the full length drops it.

// File: rtl/an_pkg.sv
package an_pkg;
  typedef enum logic [2:0] {
    ST_ENABLE,
    ST_RESTART,
    ST_ABILITY,
    ST_ACK,
    ST_CACK,
    ST_IDLE,
    ST_LINKOK
  } an_state_e;
endpackage

// File: rtl/an_link_timer.sv
module an_link_timer #(
  parameter int LONG_TICKS  = 1250000,
  parameter int SHORT_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic short_sel,
  output logic done
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] LONG_END  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] SHORT_END = CW'(SHORT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] end_val;

  assign end_val = short_sel ? SHORT_END : LONG_END;
  assign done    = (cnt_q >= end_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (!done)    cnt_q <= cnt_q + 1'b1;
  end

  // R3: the count climbs by one each cycle until expiry
  a_r3_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/an_word_match.sv
module an_word_match #(
  parameter int W       = 16,
  parameter int ACK_BIT = 14,
  parameter int HITS    = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ack_mode,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_word,
  input  logic [W-1:0] ref_word,
  output logic         hit
);
  localparam int NW = $clog2(HITS + 1);
  localparam logic [W-1:0] MASK = ~(W'(1) << ACK_BIT);

  logic [W-1:0]  cand_q;
  logic [NW-1:0] run_q, run_d;
  logic [W-1:0]  body;
  logic          good, same;

  always_comb begin
    body = rx_word & MASK;
    if (ack_mode) begin
      good = rx_word[ACK_BIT] && (body == (ref_word & MASK));
      same = good && (run_q != '0);
    end else begin
      good = (body != '0);
      same = good && (run_q != '0) && (body == cand_q);
    end
    if (!good)                    run_d = '0;
    else if (!same)               run_d = NW'(1);
    else if (run_q != NW'(HITS))  run_d = run_q + 1'b1;
    else                          run_d = run_q;
    hit = rx_valid && good && (run_d == NW'(HITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      cand_q <= '0;
    end else if (clr) begin
      run_q  <= '0;
      cand_q <= '0;
    end else if (rx_valid) begin
      run_q  <= run_d;
      cand_q <= body;
    end
  end

  // R4: acceptance only on a consumed word
  a_r4_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> rx_valid);
  // R4: an all-zero ability word never completes a run
  a_r4_zero_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_mode && ((rx_word & MASK) == '0)) |-> !hit);
endmodule

// File: rtl/an_sync_watch.sv
module an_sync_watch #(
  parameter int LOSS_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_ok,
  output logic lost
);
  localparam int SW = $clog2(LOSS_CYCLES + 1);
  localparam logic [SW-1:0] LIM = SW'(LOSS_CYCLES);

  logic [SW-1:0] low_q;

  assign lost = (low_q == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_q <= '0;
    else if (sync_ok)  low_q <= '0;
    else if (!lost)    low_q <= low_q + 1'b1;
  end

  // R11: regained alignment clears the loss indication next cycle
  a_r11_sync_recovers: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ok |=> !lost);
endmodule

// File: rtl/an_cl37_ctrl.sv
module an_cl37_ctrl #(
  parameter int WORD_W           = 16,
  parameter int ACK_BIT          = 14,
  parameter int MATCH_COUNT      = 3,
  parameter int LONG_TICKS       = 1250000,
  parameter int SHORT_TICKS      = 64,
  parameter int SYNC_LOSS_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              an_enable,
  input  logic              an_restart,
  input  logic              main_reset,
  input  logic              timer_short,
  input  logic              sync_ok,
  input  logic [WORD_W-1:0] adv_ability,
  input  logic              rx_cfg_valid,
  output logic              rx_cfg_ready,
  input  logic [WORD_W-1:0] rx_cfg_word,
  output logic [WORD_W-1:0] tx_cfg_word,
  output logic              tx_cfg_active,
  output logic [WORD_W-1:0] lp_ability,
  output logic              page_rx,
  output logic              an_complete
);
  import an_pkg::*;

  localparam logic [WORD_W-1:0] ACK_MASK = WORD_W'(1) << ACK_BIT;

  an_state_e state_q, state_d;
  logic      tmr_done, tmr_clr, m_hit, sync_lost, force_start;

  an_link_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .short_sel(timer_short), .done(tmr_done)
  );

  an_word_match #(.W(WORD_W), .ACK_BIT(ACK_BIT), .HITS(MATCH_COUNT)) u_match (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .ack_mode(state_q == ST_ACK),
    .rx_valid(rx_cfg_valid), .rx_word(rx_cfg_word), .ref_word(lp_ability), .hit(m_hit)
  );

  an_sync_watch #(.LOSS_CYCLES(SYNC_LOSS_CYCLES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .lost(sync_lost)
  );

  assign force_start = main_reset | an_restart | !an_enable | sync_lost;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ENABLE:  state_d = ST_RESTART;
      ST_RESTART: if (tmr_done) state_d = ST_ABILITY;
      ST_ABILITY: if (m_hit)    state_d = ST_ACK;
      ST_ACK:     if (m_hit)    state_d = ST_CACK;
      ST_CACK:    if (tmr_done) state_d = ST_IDLE;
      ST_IDLE:    if (tmr_done) state_d = ST_LINKOK;
      default:    state_d = ST_LINKOK;
    endcase
    if (force_start) state_d = ST_ENABLE;
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_ENABLE;
      lp_ability <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_ENABLE)
        lp_ability <= '0;
      else if (m_hit && (state_q == ST_ABILITY || state_q == ST_ACK))
        lp_ability <= rx_cfg_word;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ABILITY:       tx_cfg_word = adv_ability & ~ACK_MASK;
      ST_ACK, ST_CACK:  tx_cfg_word = adv_ability | ACK_MASK;
      default:          tx_cfg_word = '0;
    endcase
  end

  assign tx_cfg_active = (state_q == ST_RESTART) || (state_q == ST_ABILITY) ||
                         (state_q == ST_ACK) || (state_q == ST_CACK);
  assign page_rx       = (state_q == ST_CACK);
  assign an_complete   = (state_q == ST_LINKOK);
  assign rx_cfg_ready  = 1'b1;

  // R7: page flag only while acknowledging
  a_r7_page_acks: assert property (@(posedge clk) disable iff (!rst_n)
    page_rx |-> (tx_cfg_word[ACK_BIT] && tx_cfg_active));
  // R8: completion never overlaps configuration sending
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    an_complete |-> (!tx_cfg_active && !page_rx));
  // R10: management controls return the block to its start
  a_r10_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (main_reset || an_restart) |=> (!an_complete && !tx_cfg_active && lp_ability == '0));
  // R9: partner ability holds while the link stays negotiated
  a_r9_lp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (an_complete && $past(an_complete)) |-> $stable(lp_ability));
  // R12: the receive stream is never stalled
  a_r12_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cfg_ready);
endmodule

// File: tb/an_cl37_ctrl_tb_top.sv
module an_cl37_ctrl_tb_top;
  localparam int SHORT = 8;
  localparam int LONG  = 40;
  localparam int SYNCL = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        an_enable = 1'b1, an_restart = 1'b0, main_reset = 1'b0;
  logic        timer_short = 1'b1, sync_ok = 1'b1;
  logic [15:0] adv_ability = 16'h0020;
  logic        rx_cfg_valid = 1'b0;
  logic        rx_cfg_ready;
  logic [15:0] rx_cfg_word = 16'h0000;
  logic [15:0] tx_cfg_word, lp_ability;
  logic        tx_cfg_active, page_rx, an_complete;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  an_cl37_ctrl #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT), .SYNC_LOSS_CYCLES(SYNCL)) dut_i (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .an_restart(an_restart),
    .main_reset(main_reset), .timer_short(timer_short), .sync_ok(sync_ok),
    .adv_ability(adv_ability), .rx_cfg_valid(rx_cfg_valid), .rx_cfg_ready(rx_cfg_ready),
    .rx_cfg_word(rx_cfg_word), .tx_cfg_word(tx_cfg_word), .tx_cfg_active(tx_cfg_active),
    .lp_ability(lp_ability), .page_rx(page_rx), .an_complete(an_complete)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    rx_cfg_valid = 1'b0;
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    rx_cfg_valid = 1'b1;
    rx_cfg_word  = w;
  endtask

  // restart, then count cycles of zero-word sending; ends in ability detect
  task automatic restart_measure(output int c);
    @(negedge clk); rx_cfg_valid = 1'b0; an_restart = 1'b1;
    @(negedge clk); an_restart = 1'b0;
    c = 0;
    @(negedge clk);
    while (tx_cfg_active && tx_cfg_word == 16'h0000 && c < 1000) begin
      c++;
      @(negedge clk);
    end
  endtask

  task automatic negotiate(input logic [15:0] adv, input logic [15:0] p, input bit sh);
    int c;
    int lim;
    timer_short = sh;
    adv_ability = adv;
    lim = sh ? SHORT : LONG;
    restart_measure(c);
    chk(c == lim, "R2 R3 restart period", c, lim);
    chk(tx_cfg_word == (adv & 16'hBFFF), "R5 ability word", tx_cfg_word, adv & 16'hBFFF);
    repeat (3) put(p & 16'hBFFF);
    cyc();
    chk(tx_cfg_word == (adv | 16'h4000), "R6 ack word", tx_cfg_word, adv | 16'h4000);
    chk(lp_ability == (p & 16'hBFFF), "R9 lp after ability", lp_ability, p & 16'hBFFF);
    chk(!page_rx, "R7 no page before ack", page_rx, 0);
    repeat (3) put(p | 16'h4000);
    cyc();
    chk(page_rx == 1'b1, "R7 page in complete-ack", page_rx, 1);
    chk(lp_ability == (p | 16'h4000), "R9 lp with ack", lp_ability, p | 16'h4000);
    c = 0;
    while (page_rx && c < 1000) begin c++; @(negedge clk); end
    chk(c == lim, "R7 page period", c, lim);
    c = 0;
    while (!tx_cfg_active && !an_complete && c < 1000) begin c++; @(negedge clk); end
    chk(c == lim, "R8 quiet period", c, lim);
    chk(an_complete == 1'b1, "R8 complete", an_complete, 1);
    repeat (3) @(negedge clk);
    chk(an_complete && lp_ability == (p | 16'h4000), "R9 lp hold", lp_ability, p | 16'h4000);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk(!tx_cfg_active && !an_complete && !page_rx && lp_ability == 0, "R1 reset state",
        {tx_cfg_active, an_complete, page_rx}, 0);
    rst_n = 1'b1;
    chk(rx_cfg_ready == 1'b1, "R12 ready", rx_cfg_ready, 1);

    // R9: the stated example exchange
    negotiate(16'h0020, 16'h4020, 1'b1);
    chk(lp_ability == 16'h4020, "R9 example", lp_ability, 16'h4020);

    // sweep of ability pairs and timer modes
    for (int j = 0; j < 10; j++)
      negotiate(16'h01A0 ^ 16'(j << 2), 16'h0021 + 16'(j) * 16'h1111, j[0]);

    // R1: disabled
    @(negedge clk); an_enable = 1'b0;
    repeat (10) @(negedge clk);
    chk(!tx_cfg_active && !an_complete && lp_ability == 0, "R1 disabled", tx_cfg_active, 0);
    an_enable = 1'b1;
    timer_short = 1'b1;

    // R4: zero words never accepted
    restart_measure(c);
    for (int k = 0; k < 12; k++) put(k[0] ? 16'h4000 : 16'h0000);
    cyc();
    chk(tx_cfg_word[14] == 1'b0, "R4 zero rejected", tx_cfg_word, 0);
    // R4: gaps do not break a run
    put(16'h1234); put(16'h1234); repeat (5) cyc(); put(16'h1234); cyc();
    chk(tx_cfg_word[14] == 1'b1, "R4 gap tolerated", tx_cfg_word[14], 1);

    // R4: a differing word restarts the run
    restart_measure(c);
    put(16'h0A0A); put(16'h0A0A); put(16'h0B0B); put(16'h0A0A); put(16'h0A0A); cyc();
    chk(tx_cfg_word[14] == 1'b0, "R4 run restarted", tx_cfg_word[14], 0);
    put(16'h0A0A); cyc();
    chk(tx_cfg_word[14] == 1'b1 && lp_ability == 16'h0A0A, "R4 accepted after restart",
        lp_ability, 16'h0A0A);

    // R4: bit 14 ignored when comparing
    restart_measure(c);
    put(16'h0300); put(16'h4300); put(16'h0300); cyc();
    chk(tx_cfg_word[14] == 1'b1 && lp_ability == 16'h0300, "R4 ack bit ignored",
        lp_ability, 16'h0300);

    // R6: acknowledge stage needs bit 14 and matching body
    repeat (10) put(16'h0300);
    cyc();
    chk(!page_rx, "R6 no ack bit stalls", page_rx, 0);
    put(16'h4300); put(16'h4300); put(16'h4301); put(16'h4300); put(16'h4300); cyc();
    chk(!page_rx, "R6 mismatch restarts ack run", page_rx, 0);
    put(16'h4300); cyc();
    chk(page_rx == 1'b1, "R6 ack accepted", page_rx, 1);

    // R10: main reset mid-negotiation
    @(negedge clk); main_reset = 1'b1;
    @(negedge clk); main_reset = 1'b0;
    chk(!page_rx && !tx_cfg_active && lp_ability == 0, "R10 main reset clears",
        {page_rx, tx_cfg_active}, 0);

    // R10: restart after completion
    negotiate(16'h0020, 16'h4020, 1'b1);
    @(negedge clk); an_restart = 1'b1;
    @(negedge clk); an_restart = 1'b0;
    chk(!an_complete && lp_ability == 0, "R10 restart clears complete", an_complete, 0);

    // R11: synchronization loss
    negotiate(16'h0020, 16'h4020, 1'b1);
    @(negedge clk); sync_ok = 1'b0;
    repeat (SYNCL - 1) @(negedge clk);
    sync_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk(an_complete == 1'b1, "R11 short loss ignored", an_complete, 1);
    @(negedge clk); sync_ok = 1'b0;
    repeat (SYNCL) @(negedge clk);
    sync_ok = 1'b1;
    repeat (2) @(negedge clk);
    chk(an_complete == 1'b0, "R11 long loss restarts", an_complete, 0);
    chk(rx_cfg_ready == 1'b1, "R12 ready at end", rx_cfg_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule